// File: doc/BRIEF.md
# Transmit Elastic Buffer with Status

This block moves parallel transmit words from the user-side write clock into an internal read clock that runs at an unrelated phase. By default it is a small dual-clock FIFO. The write and read pointers cross between the two domains in gray code, and the user side sees a two-bit status vector: a sticky error flag and a fill-level flag. The error flag is raised by a write that arrives while the buffer is full, or by a read that arrives while it is empty. Once raised, it stays high until reset.

A mode parameter can replace the buffer with a single register stage in the read domain. This gives lower latency. In that mode both status bits read zero. One active-high reset, applied synchronously in each domain, clears the pointers, the sticky flags and the output register.

Top module: `txeb_top`

## Requirements
- R1: After reset, `status` is 2'b00 and `rd_data` is zero in both modes.
- R2: In buffered mode, words accepted on `wr_clk` with `wr_valid` high leave on `rd_data` in the order they were written. A word is registered one `rd_clk` edge after a sampled `rd_en`.
- R3: In buffered mode, `status[0]` is 1 while the number of stored words, as seen in the write domain, is at least DEPTH/2. It is 0 while that number is below DEPTH/2.
- R4: In buffered mode, a write while the buffer holds DEPTH words is dropped and sets `status[1]`.
- R5: In buffered mode, a read while the buffer is empty leaves `rd_data` unchanged. After synchronisation into the write domain, it sets `status[1]`.
- R6: `status[1]` stays 1 through later normal writes and reads. Only reset clears it.
- R7: A full buffer keeps exactly its DEPTH oldest words. A dropped word never appears on `rd_data`.
- R8: In bypass mode, `rd_data` takes the value `wr_data` had at the previous `rd_clk` edge, and `status` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | User-side write clock; status is in this domain |
| rd_clk | input | 1 | Internal read clock |
| rst | input | 1 | Active-high reset, sampled synchronously by both clocks |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Store `wr_data` on this `wr_clk` edge |
| rd_en | input | 1 | Take the next word on this `rd_clk` edge |
| rd_data | output | WIDTH | Registered read word |
| status | output | 2 | Bit 1: sticky overflow/underflow; bit 0: at least half full |

## Verification
Two situations are hard to reach from the ports: a write that collides with a full buffer, and a read that collides with an empty one. Both depend on pointer copies that arrive several cycles late across the clock boundary.

The stimulus fills the buffer one word at a time and waits after each word for the synchronisers to settle. It then offers one more word, so the full condition is certain rather than a race. It drains the buffer the same way and then reads once more. The underflow case is also repeated from a fresh reset, so that the error bit is shown to come from the read side alone after it crosses into the write domain.

// File: rtl/txeb_pkg.sv
package txeb_pkg;

    typedef enum logic {
        MODE_BUFFERED = 1'b0,
        MODE_BYPASS   = 1'b1
    } txeb_mode_e;

    typedef struct packed {
        logic err;
        logic half;
    } txeb_status_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/txeb_gray_sync.sv
module txeb_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;

    // R2
    gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(hold_q ^ $past(hold_q)) <= 1);

endmodule

// File: rtl/txeb_ram.sv
module txeb_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/txeb_wr_side.sv
module txeb_wr_side
    import txeb_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [PW-1:0]    rd_gray_s,
    input  logic             und_s,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wr_gray,
    output txeb_status_t     status_o
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill;
    logic          full;
    logic          ovf;
    txeb_status_t  stat_q;

    assign rbin_s = PW'(from_gray(32'(rd_gray_s)));
    assign fill   = wbin_q - rbin_s;
    assign full   = (fill == FULL_CNT);
    assign ovf    = wr_valid && full;
    assign we     = wr_valid && !full;
    assign waddr  = wbin_q[AW-1:0];

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            stat_q  <= '0;
        end else begin
            if (we) begin
                wbin_q  <= wbin_q + 1'b1;
                wgray_q <= PW'(to_gray(32'(wbin_q + 1'b1)));
            end
            stat_q.err  <= stat_q.err | ovf | und_s;
            stat_q.half <= (fill >= HALF_CNT);
        end
    end

    assign wr_gray  = wgray_q;
    assign status_o = stat_q;

    // R4
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_valid && full) |=> $stable(wgray_q));

    // R4
    overflow_flag_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_valid && full) |=> stat_q.err);

    // R6
    err_sticky_chk: assert property (@(posedge wr_clk) disable iff (rst)
        stat_q.err |=> stat_q.err);

endmodule

// File: rtl/txeb_rd_side.sv
module txeb_rd_side #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             rd_clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [PW-1:0]    wr_gray_s,
    input  logic [WIDTH-1:0] ram_q,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rd_gray,
    output logic [WIDTH-1:0] rd_data,
    output logic             und_flag
);
    logic [PW-1:0]    rbin_q;
    logic [PW-1:0]    rgray_q;
    logic [PW-1:0]    wbin_s;
    logic             empty;
    logic [WIDTH-1:0] dout_q;
    logic             und_q;

    assign wbin_s = PW'(txeb_pkg::from_gray(32'(wr_gray_s)));
    assign empty  = (wbin_s == rbin_q);
    assign raddr  = rbin_q[AW-1:0];

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            dout_q  <= '0;
            und_q   <= 1'b0;
        end else if (rd_en) begin
            if (empty) begin
                und_q <= 1'b1;
            end else begin
                dout_q  <= ram_q;
                rbin_q  <= rbin_q + 1'b1;
                rgray_q <= PW'(txeb_pkg::to_gray(32'(rbin_q + 1'b1)));
            end
        end
    end

    assign rd_gray  = rgray_q;
    assign rd_data  = dout_q;
    assign und_flag = und_q;

    // R5
    underflow_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_en && empty) |=> $stable(dout_q));

    // R5
    underflow_flag_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_en && empty) |=> und_q);

endmodule

// File: rtl/txeb_top.sv
module txeb_top
    import txeb_pkg::*;
#(
    parameter int         WIDTH = 16,
    parameter int         DEPTH = 8,
    parameter txeb_mode_e MODE  = MODE_BUFFERED
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [1:0]       status
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    generate
        if (MODE == MODE_BYPASS) begin : g_bypass
            logic [WIDTH-1:0] pass_q;

            always_ff @(posedge rd_clk) begin
                if (rst) begin
                    pass_q <= '0;
                end else begin
                    pass_q <= wr_data;
                end
            end

            assign rd_data = pass_q;
            assign status  = 2'b00;
        end else begin : g_buffered
            logic [PW-1:0]    wr_gray;
            logic [PW-1:0]    rd_gray;
            logic [PW-1:0]    wr_gray_s;
            logic [PW-1:0]    rd_gray_s;
            logic             we;
            logic [AW-1:0]    waddr;
            logic [AW-1:0]    raddr;
            logic [WIDTH-1:0] ram_q;
            logic             und_flag;
            logic             und_s;
            txeb_status_t     stat;

            txeb_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ram_i (
                .wr_clk (wr_clk),
                .we     (we),
                .waddr  (waddr),
                .wdata  (wr_data),
                .raddr  (raddr),
                .rdata  (ram_q)
            );

            txeb_wr_side #(.WIDTH(WIDTH), .DEPTH(DEPTH)) wr_i (
                .wr_clk    (wr_clk),
                .rst       (rst),
                .wr_valid  (wr_valid),
                .rd_gray_s (rd_gray_s),
                .und_s     (und_s),
                .we        (we),
                .waddr     (waddr),
                .wr_gray   (wr_gray),
                .status_o  (stat)
            );

            txeb_rd_side #(.WIDTH(WIDTH), .DEPTH(DEPTH)) rd_i (
                .rd_clk    (rd_clk),
                .rst       (rst),
                .rd_en     (rd_en),
                .wr_gray_s (wr_gray_s),
                .ram_q     (ram_q),
                .raddr     (raddr),
                .rd_gray   (rd_gray),
                .rd_data   (rd_data),
                .und_flag  (und_flag)
            );

            txeb_gray_sync #(.W(PW)) w2r_i (
                .clk (rd_clk),
                .rst (rst),
                .d   (wr_gray),
                .q   (wr_gray_s)
            );

            txeb_gray_sync #(.W(PW)) r2w_i (
                .clk (wr_clk),
                .rst (rst),
                .d   (rd_gray),
                .q   (rd_gray_s)
            );

            txeb_gray_sync #(.W(1)) und_i (
                .clk (wr_clk),
                .rst (rst),
                .d   (und_flag),
                .q   (und_s)
            );

            assign status = stat;
        end
    endgenerate

endmodule

// File: tb/txeb_top_tb_top.sv
module txeb_top_tb_top;
    import txeb_pkg::*;

    localparam int WIDTH = 16;
    localparam int DEPTH = 8;
    localparam int NVEC  = 8;

    // stimulus word and expected half-full flag after it is stored
    localparam logic [16:0] VEC [NVEC] = '{
        {16'h1A2B, 1'b0}, {16'h0000, 1'b0}, {16'hFFFF, 1'b0}, {16'h5A5A, 1'b1},
        {16'hA5A5, 1'b1}, {16'h0F0F, 1'b1}, {16'h8001, 1'b1}, {16'h7E3C, 1'b1}
    };

    logic             wr_clk = 1'b0;
    logic             rd_clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic [1:0]       status;
    logic [WIDTH-1:0] byp_data;
    logic [1:0]       byp_status;

    int errors = 0;
    int checks = 0;
    logic [WIDTH-1:0] got;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    txeb_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .MODE(MODE_BUFFERED)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_data(wr_data),
        .wr_valid(wr_valid), .rd_en(rd_en), .rd_data(rd_data), .status(status)
    );

    txeb_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .MODE(MODE_BYPASS)) dut_byp_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_data(wr_data),
        .wr_valid(wr_valid), .rd_en(rd_en), .rd_data(byp_data), .status(byp_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        @(negedge wr_clk);
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    task automatic pop(output logic [WIDTH-1:0] d);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (14) @(negedge wr_clk);
    endtask

    task automatic do_reset();
        @(negedge rd_clk);
        rst = 1'b1;
        repeat (4) @(negedge rd_clk);
        rst = 1'b0;
        settle();
    endtask

    initial begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 status", 32'(status), 32'h0);
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 bypass rd_data", 32'(byp_data), 32'h0);

        // R3 fill from the table, half flag after each word
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][16:1]);
            settle();
            check("R3 half flag on fill", 32'(status[0]), 32'(VEC[i][0]));
            check("R6 no error yet", 32'(status[1]), 32'h0);
        end

        // R4 write into a full buffer
        push(16'hDEAD);
        settle();
        check("R4 overflow error", 32'(status[1]), 32'h1);

        // R2 / R7 drain in order; the dropped word never shows
        for (int i = 0; i < NVEC; i++) begin
            pop(got);
            check("R2 R7 order", 32'(got), 32'(VEC[i][16:1]));
        end
        settle();
        check("R3 half flag after drain", 32'(status[0]), 32'h0);

        // R5 read from empty holds output
        pop(got);
        check("R5 hold on underflow", 32'(got), 32'(VEC[NVEC-1][16:1]));

        // R6 error survives normal traffic
        push(16'h1234);
        settle();
        pop(got);
        check("R2 word after drain", 32'(got), 32'h1234);
        settle();
        check("R6 error sticky", 32'(status[1]), 32'h1);

        // R1 / R6 reset clears
        do_reset();
        check("R6 reset clears error", 32'(status[1]), 32'h0);
        check("R1 rd_data after reset", 32'(rd_data), 32'h0);

        // R5 underflow alone from clean state
        pop(got);
        check("R5 hold zero on underflow", 32'(got), 32'h0);
        settle();
        check("R5 underflow error", 32'(status[1]), 32'h1);
        check("R3 empty half flag", 32'(status[0]), 32'h0);
        do_reset();

        // R8 bypass: one read-clock register stage, status zero
        for (int i = 0; i < 4; i++) begin
            push(VEC[i + 2][16:1]);
            @(negedge rd_clk);
            @(negedge rd_clk);
            check("R8 bypass data", 32'(byp_data), 32'(VEC[i + 2][16:1]));
            check("R8 bypass status", 32'(byp_status), 32'h0);
        end
        @(negedge wr_clk);
        wr_data = 16'hC3C3;
        @(posedge rd_clk);
        #1;
        check("R8 bypass one stage", 32'(byp_data), 32'hC3C3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule